// File: doc/BRIEF.md
# Gray-Coded Sequencer with Asynchronous Advance

This block steps through eight states held in a three-bit, fully encoded register whose codes form a cyclic Gray sequence. One control input, `adv_i`, is asynchronous to the system clock and decides whether the machine moves on. The intended system clock is slow, around 1 MHz. The advance input reaches the state logic through a single capture flip-flop followed by one settling stage. No other register ever samples the raw pin.

In every state the settled control can do only one of two things: hold the present code, or move to the one fixed successor of that code. Because the control never picks between two different next states, each legal move changes exactly one state bit. If the control arrives late, a clock edge either takes the single step or leaves the state alone. It can never land on a code that differs in two bits.

A transition checker remembers the state from the previous clock. It raises `illegal_o` whenever the current code differs from that remembered code in more than one bit. The checker is a module of its own, so it can also watch any other three-bit sequence.

Top module: `gray_seq_top`

## Requirements
- R1: While `rst_ni` is low the state is 000 and `illegal_o` is 0, and both stay that way until the first advance takes effect.
- R2: The cyclic order of codes is 000, 100, 101, 111, 110, 010, 011, 001. After 001 the sequence wraps to 000, and the only successor of 100 is 101.
- R3: While the settled control is low, the state holds its code on every clock edge.
- R4: On each clock edge where the settled control is high, the state moves exactly one position along the R2 order. If `adv_i` is held high across N consecutive rising edges, the state moves exactly N positions.
- R5: `adv_i` passes through two register stages. A rise that is first sampled at edge e leaves the state unchanged at edges e and e+1, and the first step happens at edge e+2.
- R6: Every change of `state_o` flips exactly one bit.
- R7: The checker drives `illegal_o` high while its current input differs from the value it sampled at the previous rising edge in two or more bits. It keeps the flag low for a difference of zero or one bit.
- R8: In the complete block, `illegal_o` never rises under any pattern on `adv_i`.
- R9: A pulse on `adv_i` that starts and ends between two rising edges has no effect on the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Asynchronous advance request |
| state_o | output | 3 | Current Gray state code |
| illegal_o | output | 1 | High when the last state change flipped more than one bit |

## Verification
The embedded assertions check on every cycle the following: the state holds while the settled control is low, it takes exactly one step in the R2 order while that control is high, it wraps from 001 to 000, every change flips a single bit, and the checker flag only rises on a real change. Other behaviours can only be shown by the bench's scenarios. These are the two-edge latency from the pin to the state, the step count for a held request, the lack of effect of a pulse that falls between edges, and the checker's flag under deliberately illegal sequences. The bench produces those illegal sequences on a second, standalone checker instance.

// File: rtl/gray_seq_pkg.sv
package gray_seq_pkg;
  localparam int STATE_W = 3;
  localparam int N_STATES = 1 << STATE_W;

  typedef logic [STATE_W-1:0] state_t;

  function automatic state_t gray_to_idx(input state_t g);
    state_t b;
    b[STATE_W-1] = g[STATE_W-1];
    for (int i = STATE_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic state_t idx_to_gray(input state_t b);
    return b ^ (b >> 1);
  endfunction

  // walk the reflected code downward: 000 -> 100 -> 101 ...
  function automatic state_t gray_succ(input state_t g);
    return idx_to_gray(gray_to_idx(g) - state_t'(1));
  endfunction

  function automatic int unsigned bit_diff(input state_t a, input state_t b);
    int unsigned n;
    n = 0;
    for (int i = 0; i < STATE_W; i++) n += int'(a[i] ^ b[i]);
    return n;
  endfunction
endpackage

// File: rtl/gray_seq_sync.sv
module gray_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= async_i;
    end else begin : g_chain
      // only chain_q[0] ever sees the raw pin
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], async_i};
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gray_seq_state.sv
module gray_seq_state
  import gray_seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   adv_sync_i,
  output state_t state_o
);
  state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (adv_sync_i) state_d = gray_succ(state_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= '0;
    else         state_q <= state_d;

  assign state_o = state_q;

  a_r3_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_sync_i |=> $stable(state_q));

  a_r6_one_bit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != $past(state_q)) |-> ($countones(state_q ^ $past(state_q)) == 1));

  a_r2_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_sync_i && state_q == 3'b001) |=> (state_q == 3'b000));

  a_r2_from_100: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_sync_i && state_q == 3'b100) |=> (state_q == 3'b101));

  a_r4_moves_when_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_sync_i |=> !$stable(state_q));
endmodule

// File: rtl/gray_seq_check.sv
module gray_seq_check
  import gray_seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  state_t state_i,
  output logic   illegal_o
);
  state_t prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= state_i;

  assign illegal_o = bit_diff(prev_q, state_i) > 1;

  a_r7_flag_needs_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (state_i != prev_q));
endmodule

// File: rtl/gray_seq_top.sv
module gray_seq_top
  import gray_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               adv_i,
  output logic [STATE_W-1:0] state_o,
  output logic               illegal_o
);
  logic   adv_sync;
  state_t state;

  gray_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (adv_i),
    .sync_o  (adv_sync)
  );

  gray_seq_state u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_sync_i (adv_sync),
    .state_o    (state)
  );

  gray_seq_check u_check (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .illegal_o (illegal_o)
  );

  assign state_o = state;

  a_r8_never_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !illegal_o);
endmodule

// File: tb/gray_seq_top_tb_top.sv
module gray_seq_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       adv = 1'b0;
  logic [2:0] state;
  logic       illegal;
  logic [2:0] chk_state = 3'b000;
  logic       chk_illegal;

  int checks = 0;
  int errors = 0;
  int pos = 0;
  logic [2:0] seq [8] = '{3'b000, 3'b100, 3'b101, 3'b111,
                          3'b110, 3'b010, 3'b011, 3'b001};

  always #2.5 clk = ~clk;

  gray_seq_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(adv),
    .state_o(state), .illegal_o(illegal)
  );

  gray_seq_check chk_i (
    .clk_i(clk), .rst_ni(rst_n), .state_i(chk_state), .illegal_o(chk_illegal)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // adv held high across exactly n rising edges, then pipeline drained
  task automatic advance(input int n);
    @(negedge clk);
    adv = 1'b1;
    cycles(n);
    adv = 1'b0;
    cycles(2);
    pos = (pos + n) % 8;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    adv = 1'b1;
    cycles(3);
    check("R1 state in reset", state, 0);
    check("R1 illegal in reset", illegal, 0);
    adv = 1'b0;
    rst_n = 1'b1;
    cycles(4);
    pos = 0;
    check("R1 state after reset", state, 0);
    check("R1 illegal after reset", illegal, 0);
  endtask

  task automatic t_hold;
    cycles(6);
    check("R3 hold while idle", state, seq[pos]);
  endtask

  task automatic t_walk;
    for (int i = 0; i < 8; i++) begin
      advance(1);
      check("R2 single step order", state, seq[pos]);
      check("R8 no illegal flag", illegal, 0);
    end
    check("R2 wrapped to 000", state, 0);
  endtask

  task automatic t_burst;
    advance(5);
    check("R4 five steps", state, seq[pos]);
    advance(13);
    check("R4 thirteen steps", state, seq[pos]);
    check("R8 no illegal after burst", illegal, 0);
  endtask

  task automatic t_from_100;
    while (state != 3'b100) advance(1);
    advance(1);
    check("R2 successor of 100", state, 3'b101);
  endtask

  task automatic t_latency;
    logic [2:0] start;
    start = state;
    adv = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R5 unchanged after two edges", state, start);
    @(posedge clk); @(negedge clk);
    check("R5 first step at third edge", state, seq[(pos + 1) % 8]);
    adv = 1'b0;
    cycles(2);
    pos = (pos + 3) % 8;
    check("R5 three edges give three steps", state, seq[pos]);
  endtask

  task automatic t_glitch;
    logic [2:0] start;
    start = state;
    @(negedge clk);
    #0.5 adv = 1'b1;
    #1.0 adv = 1'b0;
    cycles(4);
    check("R9 short pulse ignored", state, start);
  endtask

  task automatic t_checker;
    @(negedge clk);
    chk_state = 3'b000;
    @(posedge clk); @(negedge clk);
    chk_state = 3'b011;
    #0.5 check("R7 two-bit jump flagged", chk_illegal, 1);
    @(posedge clk); @(negedge clk);
    #0.5 check("R7 no change not flagged", chk_illegal, 0);
    chk_state = 3'b100;
    #0.5 check("R7 three-bit jump flagged", chk_illegal, 1);
    @(posedge clk); @(negedge clk);
    chk_state = 3'b101;
    #0.5 check("R7 one-bit step not flagged", chk_illegal, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_hold();
    t_walk();
    t_burst();
    t_from_100();
    t_latency();
    t_glitch();
    t_hold();
    t_checker();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule